// File: doc/BRIEF.md
# Three-Phase Commutation Output Controller

This block produces the six gate-drive outputs of a three-phase motor bridge: one high-side and one low-side output for each of the phases U, V and W. For each phase, a control word selects whether the outputs follow an incoming PWM waveform or hold a fixed level. The same word carries a 3-bit expected rotor position, which goes to position-detection logic outside the block.

Writes to the control word go into a shadow copy. The shadow copy is moved into the active copy only when a chosen commutation event arrives. The event can be a timer-1 pulse, a timer-2 pulse, a position-detection pulse, or nothing, in which case the transfer is immediate. An optional qualifier delays the transfer until the next PWM-period sync pulse. The field that selects the event source is not buffered, so it takes effect in the same cycle it is written.

Each side of the bridge has its own polarity input, applied just before the output registers. This lets the block drive gate drivers that are either active-high or active-low.

Top module: `commut_out_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every high-side output takes the level of `hi_inv` and every low-side output takes the level of `lo_inv`, which is the inactive level for that side. The edge also clears the shadow copy, the active copy and the pending event, and sets the sync source to 00. After reset, each phase is therefore in fixed mode with level 0, and `exp_pos` is 0.
- R2: The control word `wr_data` is laid out as follows. Bit 11 is the PWM-sync qualifier. Bits 10:8 hold the expected position. Bits 7:6 select the sync source. Bits 5:3 are the PWM-mode enables for W, V and U (bit 3 is U). Bits 2:0 are the fixed levels for W, V and U (bit 0 is U).
- R3: With sync source 00 and the qualifier clear, a write becomes active at the clock edge that samples it. `exp_pos` and the output control change in the following cycle.
- R4: With sync source 01 (timer 1), 10 (timer 2) or 11 (position), the buffered fields stay unchanged until a pulse arrives on the selected event input. Pulses on the other event inputs have no effect.
- R5: The sync-source field is never buffered. A write's own sync-source value decides whether a commit happens in that same cycle, and it decides every later commit.
- R6: With the qualifier set, a selected event only arms a transfer. The transfer happens at the first `pwm_sync` pulse in the same cycle as the event or after it. A `pwm_sync` pulse with no armed or coincident event does nothing.
- R7: When a write and a commit happen in the same cycle, the newly written value is the one that becomes active.
- R8: In fixed mode, a level bit of 1 drives that phase's high side active and its low side inactive. A level bit of 0 does the reverse.
- R9: In PWM mode, the high side follows that phase's `pwm_in` bit and the low side follows its complement. Both are registered with one cycle of delay.
- R10: When `hi_inv` is 1, the high-side outputs are active-low; otherwise they are active-high. `lo_inv` sets the low side in the same way. Each polarity input acts only on its own side.
- R11: `exp_pos` always shows the position field of the active copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 12 | Control word written when `wr_en` is high |
| pwm_in | input | 3 | PWM waveforms, bit 0 = U, 1 = V, 2 = W |
| pwm_sync | input | 1 | PWM-period sync pulse |
| tmr1_evt | input | 1 | Timer-1 event pulse |
| tmr2_evt | input | 1 | Timer-2 event pulse |
| pos_evt | input | 1 | Position-detection event pulse |
| hi_inv | input | 1 | High-side polarity, 1 = active-low |
| lo_inv | input | 1 | Low-side polarity, 1 = active-low |
| hi_out | output | 3 | High-side gate outputs, bit 0 = U |
| lo_out | output | 3 | Low-side gate outputs, bit 0 = U |
| exp_pos | output | 3 | Expected position from the active copy |

## Verification
The block has no parameters, so the bench builds it exactly as written. Because the 12-bit layout is fixed, one bench can reach every sync-source code, both settings of the qualifier and all four polarity combinations. The bench lines up writes against event pulses in the same cycle and in later cycles. It also sends pulses on the event inputs that are not selected, to show they are ignored, and it sends sync pulses before any event has armed a transfer.

// File: rtl/commut_out_ctrl.sv
module commut_out_ctrl (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [11:0] wr_data,
  input  logic [2:0]  pwm_in,
  input  logic        pwm_sync,
  input  logic        tmr1_evt,
  input  logic        tmr2_evt,
  input  logic        pos_evt,
  input  logic        hi_inv,
  input  logic        lo_inv,
  output logic [2:0]  hi_out,
  output logic [2:0]  lo_out,
  output logic [2:0]  exp_pos
);

  // shadow: {qualify, pos[2:0], mode[2:0], lvl[2:0]}; active drops the qualifier
  logic [1:0] sel_q;
  logic [9:0] shd_q;
  logic [8:0] act_q;
  logic       armed_q;

  logic [9:0] shd_nx;
  logic [1:0] sel_eff;
  logic       qual_eff;
  logic       evt;
  logic       commit;
  logic [2:0] src;

  assign shd_nx   = wr_en ? {wr_data[11:8], wr_data[5:0]} : shd_q;
  assign sel_eff  = wr_en ? wr_data[7:6] : sel_q;
  assign qual_eff = shd_nx[9];

  always_comb begin
    case (sel_eff)
      2'b00:   evt = 1'b1;
      2'b01:   evt = tmr1_evt;
      2'b10:   evt = tmr2_evt;
      default: evt = pos_evt;
    endcase
  end

  assign commit = qual_eff ? (pwm_sync & (evt | armed_q)) : evt;

  assign src     = (act_q[5:3] & pwm_in) | (~act_q[5:3] & act_q[2:0]);
  assign exp_pos = act_q[8:6];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 2'b00;
      shd_q   <= '0;
      act_q   <= '0;
      armed_q <= 1'b0;
      hi_out  <= {3{hi_inv}};
      lo_out  <= {3{lo_inv}};
    end else begin
      sel_q   <= sel_eff;
      shd_q   <= shd_nx;
      if (commit) act_q <= shd_nx[8:0];
      armed_q <= qual_eff & (armed_q | evt) & ~commit;
      hi_out  <= src ^ {3{hi_inv}};
      lo_out  <= ~src ^ {3{lo_inv}};
    end
  end

  // R1: the cycle after reset, outputs sit at the inactive level and position is cleared
  a_r1_reset_inactive: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hi_out == {3{$past(hi_inv)}} && lo_out == {3{$past(lo_inv)}} && exp_pos == 3'd0));

  // R8 / R9: outside reset exactly one side of each phase is active
  a_r8_one_side_active: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((hi_out ^ {3{$past(hi_inv)}}) ^ (lo_out ^ {3{$past(lo_inv)}})) == 3'b111));

  // R3: immediate mode without qualifier commits the written position at once
  a_r3_immediate: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_data[7:6]) == 2'b00 && !$past(wr_data[11]))
      |-> exp_pos == $past(wr_data[10:8]));

  // R6: with the qualifier on, the active copy only moves on a sync pulse
  a_r6_sync_gate: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(qual_eff) && exp_pos != $past(exp_pos)) |-> $past(pwm_sync));

  // R4: timer-1 source changes the active copy only on a timer-1 pulse or an armed transfer
  a_r4_tmr1_only: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_eff) == 2'b01 && exp_pos != $past(exp_pos))
      |-> ($past(tmr1_evt) || $past(armed_q)));

endmodule

// File: tb/commut_out_ctrl_bench.sv
module commut_out_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_data = '0;
  logic [2:0]  pwm_in = '0;
  logic        pwm_sync = 1'b0, tmr1_evt = 1'b0, tmr2_evt = 1'b0, pos_evt = 1'b0;
  logic        hi_inv = 1'b0, lo_inv = 1'b0;
  logic [2:0]  hi_out, lo_out, exp_pos;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  string      tag_q[$];
  logic [8:0] exp_q[$];

  // reference state built from the requirements
  logic [1:0] m_sel = 2'b00;
  logic [9:0] m_shd = '0;
  logic [8:0] m_act = '0;
  logic       m_arm = 1'b0;

  always #2.5 clk = ~clk;

  commut_out_ctrl u_commut_out_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pwm_in(pwm_in), .pwm_sync(pwm_sync), .tmr1_evt(tmr1_evt),
    .tmr2_evt(tmr2_evt), .pos_evt(pos_evt), .hi_inv(hi_inv), .lo_inv(lo_inv),
    .hi_out(hi_out), .lo_out(lo_out), .exp_pos(exp_pos));

  task automatic step(input string tag);
    logic [2:0] e_hi, e_lo, drv;
    logic [9:0] nshd;
    logic [1:0] nsel;
    logic ev, cm;
    if (rst) begin
      e_hi = {3{hi_inv}};
      e_lo = {3{lo_inv}};
      m_sel = 2'b00; m_shd = '0; m_act = '0; m_arm = 1'b0;
    end else begin
      for (int i = 0; i < 3; i++)
        drv[i] = m_act[3+i] ? pwm_in[i] : m_act[i];
      e_hi = drv ^ {3{hi_inv}};
      e_lo = ~drv ^ {3{lo_inv}};
      nshd = wr_en ? {wr_data[11:8], wr_data[5:0]} : m_shd;
      nsel = wr_en ? wr_data[7:6] : m_sel;
      ev = (nsel == 2'b00) || (nsel == 2'b01 && tmr1_evt) ||
           (nsel == 2'b10 && tmr2_evt) || (nsel == 2'b11 && pos_evt);
      if (nshd[9]) begin
        cm = pwm_sync && (ev || m_arm);
        m_arm = (ev || m_arm) && !cm;
      end else begin
        cm = ev;
        m_arm = 1'b0;
      end
      if (cm) m_act = nshd[8:0];
      m_shd = nshd;
      m_sel = nsel;
    end
    tag_q.push_back(tag);
    exp_q.push_back({e_hi, e_lo, m_act[8:6]});
    @(negedge clk);
    wr_en = 1'b0; pwm_sync = 1'b0; tmr1_evt = 1'b0; tmr2_evt = 1'b0; pos_evt = 1'b0;
  endtask

  task automatic wr(input logic [11:0] d, input string tag);
    wr_en = 1'b1;
    wr_data = d;
    step(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if ({hi_out, lo_out, exp_pos} !== e) begin
          miscompares++;
          $display("FAIL %s: hi/lo/pos actual %b/%b/%0d expected %b/%b/%0d",
                   t, hi_out, lo_out, exp_pos, e[8:6], e[5:3], e[2:0]);
        end
      end
    end
  end

  initial begin
    #250000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset with both polarities
    step("R1"); step("R1");
    hi_inv = 1'b1; lo_inv = 1'b1; step("R1");
    hi_inv = 1'b0; lo_inv = 1'b0; step("R1");
    rst = 1'b0;
    step("R1"); step("R1");

    // R3 R8 R11: immediate, pos 5, levels U=1 V=0 W=1
    wr(12'h505, "R3 R11"); step("R3 R8 R11"); step("R8");
    wr(12'h302, "R3 R8 R11"); step("R8 R11");

    // R9: all phases in PWM mode
    wr(12'h038, "R9");
    pwm_in = 3'b101; step("R9");
    pwm_in = 3'b010; step("R9");
    pwm_in = 3'b110; step("R9");
    pwm_in = 3'b001; step("R9");

    // R2: mixed mode, U PWM, V PWM, W fixed 0, U level ignored
    wr(12'h019, "R2");
    pwm_in = 3'b011; step("R2");
    pwm_in = 3'b100; step("R2");
    pwm_in = 3'b000;

    // R10: each polarity alone
    hi_inv = 1'b1; step("R10"); step("R10");
    hi_inv = 1'b0; lo_inv = 1'b1; step("R10"); step("R10");
    hi_inv = 1'b1; step("R10");
    hi_inv = 1'b0; lo_inv = 1'b0; step("R10");

    // R4: timer-1 source, other pulses ignored
    wr(12'h347, "R4");
    tmr2_evt = 1'b1; step("R4");
    pos_evt = 1'b1; step("R4");
    pwm_sync = 1'b1; step("R4");
    tmr1_evt = 1'b1; step("R4"); step("R4 R11");

    // R7: write together with the selected event
    wr(12'h2C2, "R5");
    wr_en = 1'b1; wr_data = 12'h4C5; pos_evt = 1'b1; step("R7");
    step("R7 R11");

    // R5: written source decides same-cycle commit
    wr_en = 1'b1; wr_data = 12'h180; tmr1_evt = 1'b1; step("R5");
    step("R5");
    tmr2_evt = 1'b1; step("R5"); step("R5 R11");

    // R6: qualifier set, timer-1 source
    wr(12'hC41, "R6");
    tmr1_evt = 1'b1; step("R6");
    step("R6"); step("R6");
    pwm_sync = 1'b1; step("R6"); step("R6 R11");
    wr(12'hE47, "R6");
    tmr1_evt = 1'b1; pwm_sync = 1'b1; step("R6"); step("R6");
    wr(12'hA41, "R6");
    pwm_sync = 1'b1; step("R6"); step("R6");
    tmr1_evt = 1'b1; step("R6");
    pwm_sync = 1'b1; step("R6"); step("R6 R11");

    // R1: reset mid-run clears everything
    rst = 1'b1; step("R1");
    rst = 1'b0; step("R1"); step("R1");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule